// File: doc/BRIEF.md
# FPGA Slave-Serial Configuration Sequencer

This block loads a configuration image into an FPGA through its slave-serial port. It drives an 8-bit pin word, one new word per bit-clock tick, where each bit position is wired to one configuration pin. A tick is derived from the system clock by a parameterized divider. On a start strobe the block first emits a repeated shutdown pattern that halts the running FPGA design. It then pulses the program line and polls the INIT input a bounded number of times. After that it streams the image, two pin words per image bit.

The clock line is inverted on the board, so driving the CCLK bit high is idle from the FPGA's point of view. Image bytes arrive on a valid/ready handshake with a last flag. The block reports progress on busy, a one-cycle done pulse on success, and an error flag when INIT never appears. Reading the image from storage and descrambling it happen upstream and are not part of this block.

Top module: `cfg_serial_loader`

## Requirements
- R1: After reset, and whenever the block is idle, `pin_o` is 0x01 (bit0 = clock line at its idle high level), `pin_oe_o` is 0x00 and `busy_o`, `done_o`, `err_o` and `img_ready_o` are 0.
- R2: A `start_i` sampled high while idle raises `busy_o` and clears `err_o` on that edge. While busy, `pin_oe_o` is 0xDF, so every bit except bit5 (the INIT position) is an output. Bit5 of `pin_o` is never driven high.
- R3: Pin words change only on ticks. Tick k after the start edge lands on the k*TICK_DIV-th rising clock edge. Ticks 1 to 8*SHUT_REPS carry the shutdown pattern: bit7 is set, and bit2 or bit3 is set depending on the step index i mod 8. Bit3 is used for i in {2,4,6} and bit2 for the rest, giving the words 0x84 and 0x88.
- R4: The next 10 ticks carry the program pulse: 0x01, 0x03, 0x03, then 0x01 seven times. Bit1 is the program line.
- R5: INIT is first sampled on the tick after the program pulse. If it is low, it is sampled again every POLL_GAP_TICKS+1 ticks, up to POLL_MAX samples. During polling `pin_o` stays 0x01.
- R6: If INIT is low at all POLL_MAX samples, then on the tick of the last sample `err_o` rises, `busy_o` falls and `pin_o` is 0x01. `err_o` stays high until the next start.
- R7: Once INIT is seen high, image bytes are streamed in handshake order, MSB first. Each bit b produces the word (b<<6)|0x01 followed by the word b<<6, where bit6 is the data line. A new byte is accepted back-to-back with no idle tick.
- R8: An image of N bytes produces exactly 16*N stream words.
- R9: On the tick after the last stream word, `pin_o` returns to 0x01, `busy_o` falls and `done_o` is high for exactly one clock cycle.
- R10: `img_ready_o` is high only while polling or streaming, and only when the byte buffer is empty or is being emptied on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, honoured only while idle |
| img_byte_i | input | 8 | Image byte |
| img_valid_i | input | 1 | Image byte valid |
| img_last_i | input | 1 | Marks the final image byte |
| img_ready_o | output | 1 | Image byte accepted on this edge when valid |
| init_i | input | 1 | INIT level from the FPGA |
| pin_o | output | 8 | Configuration pin word |
| pin_oe_o | output | 8 | Output enable for each pin word bit |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse on successful completion |
| err_o | output | 1 | INIT never seen; held until next start |

## Verification
The bound checker watches properties that hold on every cycle. It checks that the idle word is present whenever the block is not busy, and that the output-enable mask follows busy. It checks that the INIT bit is never driven, that every word carrying bit7 is a well-formed shutdown word, and that done is a single-cycle pulse that never coincides with error or busy. It also checks that busy rises only on a start and that ready never appears while idle. The exact order of the shutdown, program and stream words, the bit placement within each word, the poll spacing, the tick on which INIT is finally seen or given up on, and the word count per image can only be shown by the bench. It replays sessions with known images and INIT timing and compares each tick's word against a model.

// File: rtl/cfg_sl_pkg.sv
package cfg_sl_pkg;

  localparam int WORD_W    = 8;
  localparam int SHUT_STEP = 8;
  localparam int PROG_LEN  = 10;

  localparam logic [WORD_W-1:0] IDLE_WORD = 8'h01;
  localparam logic [WORD_W-1:0] OE_MASK   = 8'hDF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREP,
    ST_POLL,
    ST_STREAM,
    ST_FINISH
  } seq_state_t;

  // Shutdown step: bit7 always on; bit3 on even steps from 2, otherwise bit2
  function automatic logic [WORD_W-1:0] shut_word(input logic [2:0] idx);
    logic [WORD_W-1:0] w;
    w    = '0;
    w[7] = 1'b1;
    if (idx >= 3'd2 && !idx[0]) w[3] = 1'b1;
    else                        w[2] = 1'b1;
    return w;
  endfunction

  // Program pulse step: clock idle high, program line up on steps 1 and 2
  function automatic logic [WORD_W-1:0] prog_word(input logic [3:0] idx);
    logic [WORD_W-1:0] w;
    w = IDLE_WORD;
    if (idx == 4'd1 || idx == 4'd2) w[1] = 1'b1;
    return w;
  endfunction

endpackage

// File: rtl/cfg_sl_tick.sv
module cfg_sl_tick #(
  parameter int TICK_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  generate
    if (TICK_DIV <= 1) begin : g_every
      logic armed;
      always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
      end
      assign tick = armed & ~restart;
    end else begin : g_div
      localparam int CW = $clog2(TICK_DIV);
      logic [CW-1:0] cnt;
      assign tick = !restart && (cnt == CW'(TICK_DIV - 1));
      always_ff @(posedge clk) begin
        if (rst || restart)                cnt <= '0;
        else if (cnt == CW'(TICK_DIV - 1)) cnt <= '0;
        else                               cnt <= cnt + CW'(1);
      end
    end
  endgenerate
endmodule

// File: rtl/cfg_sl_prep.sv
module cfg_sl_prep
  import cfg_sl_pkg::*;
#(
  parameter int SHUT_REPS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              step,
  output logic [WORD_W-1:0] word,
  output logic              last
);
  localparam int SHUT_TOTAL = SHUT_REPS * SHUT_STEP;
  localparam int TOTAL      = SHUT_TOTAL + PROG_LEN;
  localparam int SW         = $clog2(TOTAL + 1);

  logic [SW-1:0] pos;
  logic [3:0]    prog_idx;

  assign prog_idx = 4'(pos - SW'(SHUT_TOTAL));
  assign word     = (pos < SW'(SHUT_TOTAL)) ? shut_word(pos[2:0]) : prog_word(prog_idx);
  assign last     = (pos == SW'(TOTAL - 1));

  always_ff @(posedge clk) begin
    if (rst || clear) pos <= '0;
    else if (step)    pos <= pos + SW'(1);
  end
endmodule

// File: rtl/cfg_sl_poll.sv
module cfg_sl_poll #(
  parameter int POLL_MAX       = 10,
  parameter int POLL_GAP_TICKS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic step,
  input  logic init_in,
  output logic found,
  output logic exhausted
);
  localparam int PW = $clog2(POLL_MAX + 1);
  localparam int GW = (POLL_GAP_TICKS < 1) ? 1 : $clog2(POLL_GAP_TICKS + 1);

  logic [PW-1:0] polls;
  logic [GW-1:0] gap;
  logic          at_poll;

  assign at_poll   = (gap == '0);
  assign found     = step && at_poll && init_in;
  assign exhausted = step && at_poll && !init_in && (polls == PW'(POLL_MAX - 1));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      polls <= '0;
      gap   <= '0;
    end else if (step) begin
      if (!at_poll) begin
        gap <= gap - GW'(1);
      end else if (!init_in) begin
        polls <= polls + PW'(1);
        gap   <= GW'(POLL_GAP_TICKS);
      end
    end
  end
endmodule

// File: rtl/cfg_sl_shift.sv
module cfg_sl_shift
  import cfg_sl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              accept_en,
  input  logic              step,
  input  logic [7:0]        in_byte,
  input  logic              in_valid,
  input  logic              in_last,
  output logic              in_ready,
  output logic [WORD_W-1:0] word,
  output logic              emit,
  output logic              img_end
);
  logic [7:0] byte_q;
  logic       have;
  logic       is_last;
  logic [2:0] bit_idx;
  logic       half;
  logic       consume;
  logic       load;

  assign emit     = step && have;
  assign consume  = emit && half && (bit_idx == 3'd0);
  assign in_ready = accept_en && (!have || consume);
  assign load     = in_ready && in_valid;
  assign img_end  = consume && is_last;

  always_comb begin
    word    = '0;
    word[6] = byte_q[bit_idx];
    word[0] = ~half;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      have    <= 1'b0;
      half    <= 1'b0;
      bit_idx <= 3'd7;
      is_last <= 1'b0;
      byte_q  <= '0;
    end else begin
      if (emit) begin
        half <= ~half;
        if (half) bit_idx <= bit_idx - 3'd1;
      end
      if (load) begin
        byte_q  <= in_byte;
        is_last <= in_last;
        have    <= 1'b1;
      end else if (consume) begin
        have <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import cfg_sl_pkg::*;
#(
  parameter int TICK_DIV       = 133,
  parameter int SHUT_REPS      = 4,
  parameter int POLL_MAX       = 10,
  parameter int POLL_GAP_TICKS = 7500
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic [7:0] img_byte_i,
  input  logic       img_valid_i,
  input  logic       img_last_i,
  output logic       img_ready_o,
  input  logic       init_i,
  output logic [7:0] pin_o,
  output logic [7:0] pin_oe_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       err_o
);
  seq_state_t        state;
  logic              idle;
  logic              tick;
  logic [WORD_W-1:0] prep_word;
  logic              prep_last;
  logic              poll_found;
  logic              poll_exh;
  logic [WORD_W-1:0] sh_word;
  logic              sh_emit;
  logic              sh_end;

  assign idle = (state == ST_IDLE);

  cfg_sl_tick #(.TICK_DIV(TICK_DIV)) tick_i (
    .clk(clk), .rst(rst), .restart(idle), .tick(tick)
  );

  cfg_sl_prep #(.SHUT_REPS(SHUT_REPS)) prep_i (
    .clk(clk), .rst(rst), .clear(idle),
    .step(tick && state == ST_PREP),
    .word(prep_word), .last(prep_last)
  );

  cfg_sl_poll #(.POLL_MAX(POLL_MAX), .POLL_GAP_TICKS(POLL_GAP_TICKS)) poll_i (
    .clk(clk), .rst(rst), .clear(idle),
    .step(tick && state == ST_POLL), .init_in(init_i),
    .found(poll_found), .exhausted(poll_exh)
  );

  cfg_sl_shift shift_i (
    .clk(clk), .rst(rst), .clear(idle),
    .accept_en(state == ST_POLL || state == ST_STREAM),
    .step(tick && state == ST_STREAM),
    .in_byte(img_byte_i), .in_valid(img_valid_i), .in_last(img_last_i),
    .in_ready(img_ready_o), .word(sh_word), .emit(sh_emit), .img_end(sh_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      pin_o    <= IDLE_WORD;
      pin_oe_o <= '0;
      busy_o   <= 1'b0;
      done_o   <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start_i) begin
            state    <= ST_PREP;
            busy_o   <= 1'b1;
            err_o    <= 1'b0;
            pin_oe_o <= OE_MASK;
          end
        end
        ST_PREP: begin
          if (tick) begin
            pin_o <= prep_word;
            if (prep_last) state <= ST_POLL;
          end
        end
        ST_POLL: begin
          if (poll_found) begin
            state <= ST_STREAM;
          end else if (poll_exh) begin
            state    <= ST_IDLE;
            err_o    <= 1'b1;
            busy_o   <= 1'b0;
            pin_oe_o <= '0;
            pin_o    <= IDLE_WORD;
          end
        end
        ST_STREAM: begin
          if (sh_emit) pin_o <= sh_word;
          if (sh_end)  state <= ST_FINISH;
        end
        ST_FINISH: begin
          if (tick) begin
            state    <= ST_IDLE;
            pin_o    <= IDLE_WORD;
            done_o   <= 1'b1;
            busy_o   <= 1'b0;
            pin_oe_o <= '0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_serial_loader_chk.sv
module cfg_serial_loader_chk (
  input logic       clk,
  input logic       rst,
  input logic       start_i,
  input logic       img_ready_o,
  input logic [7:0] pin_o,
  input logic [7:0] pin_oe_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       err_o
);
  assert_idle_word_R1: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> pin_o == 8'h01);

  assert_oe_mask_R2: assert property (@(posedge clk) disable iff (rst)
    pin_oe_o == (busy_o ? 8'hDF : 8'h00));

  assert_init_undriven_R2: assert property (@(posedge clk) disable iff (rst)
    !pin_o[5]);

  assert_busy_from_start_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(start_i));

  assert_shut_shape_R3: assert property (@(posedge clk) disable iff (rst)
    pin_o[7] |-> (pin_o[1:0] == 2'b00 && !pin_o[6] && $countones(pin_o[3:2]) == 1));

  assert_err_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (!busy_o && !done_o));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  assert_ready_busy_R10: assert property (@(posedge clk) disable iff (rst)
    img_ready_o |-> busy_o);
endmodule

bind cfg_serial_loader cfg_serial_loader_chk chk_i (.*);

// File: tb/cfg_serial_loader_tb.sv
`timescale 1ns/1ps
module cfg_serial_loader_tb_top;
  localparam int D    = 2;
  localparam int G    = 3;
  localparam int PM   = 10;
  localparam int REPS = 4;
  localparam int PREP = REPS * 8 + 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [7:0] img_byte_i = '0;
  logic       img_valid_i = 1'b0;
  logic       img_last_i = 1'b0;
  logic       img_ready_o;
  logic       init_i = 1'b0;
  logic [7:0] pin_o;
  logic [7:0] pin_oe_o;
  logic       busy_o;
  logic       done_o;
  logic       err_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [7:0] img [0:15];

  always #2.5 clk = ~clk;

  cfg_serial_loader #(.TICK_DIV(D), .SHUT_REPS(REPS), .POLL_MAX(PM), .POLL_GAP_TICKS(G)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .img_byte_i(img_byte_i),
    .img_valid_i(img_valid_i), .img_last_i(img_last_i), .img_ready_o(img_ready_o),
    .init_i(init_i), .pin_o(pin_o), .pin_oe_o(pin_oe_o), .busy_o(busy_o),
    .done_o(done_o), .err_o(err_o)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // Model of the word expected on tick k of a session with n bytes, INIT found on poll pk
  function automatic int exp_word(input int k, input int n, input int pk);
    int hold_end, j, b, bit_pos;
    hold_end = PREP + pk * (G + 1) + 1;
    if (k <= REPS * 8) begin
      j = (k - 1) % 8;
      return (j >= 2 && j % 2 == 0) ? 'h88 : 'h84;
    end
    if (k <= PREP) return (k == REPS * 8 + 2 || k == REPS * 8 + 3) ? 'h03 : 'h01;
    if (k <= hold_end) return 'h01;
    if (k <= hold_end + 16 * n) begin
      j = k - hold_end - 1;
      b = j / 16;
      bit_pos = 7 - (j % 16) / 2;
      return (int'(img[b][bit_pos]) << 6) | ((j % 2 == 0) ? 1 : 0);
    end
    return 'h01;
  endfunction

  function automatic string region(input int k, input int n, input int pk);
    int hold_end;
    hold_end = PREP + pk * (G + 1) + 1;
    if (k <= REPS * 8) return "R3";
    if (k <= PREP) return "R4";
    if (k <= hold_end) return "R5";
    if (k <= hold_end + 16 * n) return "R7";
    return "R9";
  endfunction

  task automatic pulse_start();
    @(negedge clk);
    start_i = 1'b1;
    @(posedge clk);
    #1 start_i = 1'b0;
  endtask

  task automatic feed(input int n);
    for (int i = 0; i < n; i++) begin
      img_byte_i  = img[i];
      img_last_i  = (i == n - 1);
      img_valid_i = 1'b1;
      @(negedge clk);
      while (!img_ready_o) @(negedge clk);
      @(posedge clk);
      #1;
    end
    img_valid_i = 1'b0;
    img_last_i  = 1'b0;
  endtask

  task automatic run_ok(input int n, input int pk);
    int total;
    total = PREP + pk * (G + 1) + 1 + 16 * n + 1;
    init_i = 1'b0;
    pulse_start();
    fork
      feed(n);
      begin
        for (int k = 1; k <= total; k++) begin
          repeat (D) @(posedge clk);
          #1;
          chk(int'(pin_o) == exp_word(k, n, pk), region(k, n, pk), "pin word", pin_o, exp_word(k, n, pk));
          if (k == 1) begin
            chk(err_o == 1'b0, "R2", "err cleared by start", err_o, 0);
            chk(pin_oe_o == 8'hDF, "R2", "oe mask while busy", pin_oe_o, 'hDF);
          end
          if (k < total) begin
            chk(busy_o == 1'b1 && done_o == 1'b0, "R9", "busy until end", {busy_o, done_o}, 2);
          end else begin
            chk(done_o == 1'b1 && busy_o == 1'b0 && err_o == 1'b0, "R8", "done after 16*N words",
                {done_o, busy_o, err_o}, 4);
            chk(pin_oe_o == 8'h00, "R1", "oe released", pin_oe_o, 0);
          end
          if (k == PREP + pk * (G + 1)) init_i = 1'b1;
        end
        @(posedge clk);
        #1;
        chk(done_o == 1'b0, "R9", "done one cycle", done_o, 0);
        chk(img_ready_o == 1'b0, "R10", "ready low when idle", img_ready_o, 0);
      end
    join
    init_i = 1'b0;
  endtask

  task automatic run_err();
    int last_poll;
    last_poll = PREP + 1 + (PM - 1) * (G + 1);
    init_i = 1'b0;
    pulse_start();
    for (int k = 1; k <= last_poll; k++) begin
      repeat (D) @(posedge clk);
      #1;
      chk(int'(pin_o) == exp_word(k, 0, PM), (k <= PREP) ? "R4" : "R5", "pin word err run",
          pin_o, exp_word(k, 0, PM));
      if (k == PREP + 1)
        chk(img_ready_o == 1'b1, "R10", "ready while polling with empty buffer", img_ready_o, 1);
      if (k < last_poll)
        chk(err_o == 1'b0 && busy_o == 1'b1, "R5", "still polling", {err_o, busy_o}, 1);
      else
        chk(err_o == 1'b1 && busy_o == 1'b0 && done_o == 1'b0, "R6", "error on last poll",
            {err_o, busy_o, done_o}, 4);
    end
    repeat (5) @(posedge clk);
    #1;
    chk(err_o == 1'b1, "R6", "error sticky", err_o, 1);
    chk(pin_o == 8'h01 && pin_oe_o == 8'h00, "R1", "idle after error", {pin_o, pin_oe_o}, 'h0100);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) img[i] = 8'($urandom);
    img[0] = 8'hA5;
    img[1] = 8'h00;
    img[2] = 8'hFF;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(pin_o == 8'h01, "R1", "reset word", pin_o, 1);
    chk(pin_oe_o == 8'h00, "R1", "reset oe", pin_oe_o, 0);
    chk({busy_o, done_o, err_o, img_ready_o} == 4'b0, "R1", "reset flags",
        {busy_o, done_o, err_o, img_ready_o}, 0);

    run_ok(3, 0);
    run_err();
    run_ok(1, PM - 1);
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < 16; i++) img[i] = 8'($urandom);
      run_ok(1 + int'($urandom_range(5)), int'($urandom_range(PM - 1)));
    end
    finished = 1;
    report();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=hung expected=complete");
      report();
      $finish;
    end
  end
endmodule